// File: doc/BRIEF.md
# Multi-Slot Clock Edge Delay Tracker

This block delays a clock waveform inside a time-stepped emulator. Each cycle of the emulator clock it compares the modelled clock level with the level from one cycle before. Every change, rising or falling, is parked in one of a fixed number of slots, and the slots are taken in turn. The parked slot keeps the new level and the time still to elapse before that level should appear on the output. That time is a programmable delay: a fraction of a nominal period chosen by a control code, plus a signed additive jitter term, and never below zero.

Every cycle the block publishes the shortest remaining time among its occupied slots as its time-step request. A global arbiter outside the block grants a step. Slots whose remaining time equals the granted step fire: they drive their stored level onto the output and become free. All slots count down by the granted step. Free slots take part in the request as the maximum-step input, so with no edge in flight the request equals that maximum.

Top module: `edge_delay_tracker`

## Requirements
- R1: While rst_ni is low, lvl_o is 0, no slot is occupied, and req_o equals step_max_i.
- R2: The delay loaded for an edge is (code_i × PERIOD) / 2^CODE_W plus the signed jit_i, in time LSBs; when the sum is negative the delay is 0. With the defaults (PERIOD 256, CODE_W 4) one code step is 16 LSBs.
- R3: An edge is any cycle in which lvl_i differs from its value in the previous cycle; rising and falling edges are treated alike. The level held during reset counts as 0.
- R4: The slot pointer starts at slot 0, moves to the next slot once per edge, wraps from DEPTH−1 to 0, and holds when there is no edge.
- R5: On an edge the pointed slot becomes occupied with the delay of R2 as its remaining time and the current lvl_i as its level; on every clock edge every other slot subtracts step_i from its remaining time.
- R6: An occupied slot fires in a cycle where its remaining time equals step_i, and is freed at the next clock edge unless it is loaded again in that same cycle.
- R7: req_o is the minimum over all slots of the slot's remaining time if occupied, or step_max_i if free; with no occupied slot req_o equals step_max_i.
- R8: lvl_o rises to 1 in a cycle where a firing slot holds level 1, falls to 0 where a firing slot holds level 0, and otherwise keeps its value from the previous cycle.
- R9: If slots holding level 1 and level 0 fire in the same cycle, lvl_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Emulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_i | input | 1 | Modelled clock level to be delayed |
| code_i | input | CODE_W | Delay control code |
| jit_i | input | JIT_W | Signed additive jitter in time LSBs |
| step_i | input | T_W | Time step granted this cycle |
| step_max_i | input | T_W | Largest step the block may request |
| req_o | output | T_W | Requested time step (minimum pending time) |
| lvl_o | output | 1 | Delayed clock level |

## Verification
A slot that keeps or loses its occupancy wrongly shows on req_o in the very next cycle: a slot stuck occupied pulls the request down to a stale or wrapped time, and a slot lost early lets the request jump back to step_max_i. A wrong remaining time or stored level stays hidden until the cycle when the slot should fire, where lvl_o fails to toggle or toggles to the wrong level. A pointer that fails to wrap shows only after DEPTH edges, when the reused slot never fires, so the stimulus drives more edges than there are slots.

// File: rtl/edt_pkg.sv
package edt_pkg;
  // Slot pointer width, at least one bit.
  function automatic int ptr_w(input int depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/edt_delay_calc.sv
module edt_delay_calc #(
  parameter int CODE_W = 4,
  parameter int T_W    = 16,
  parameter int JIT_W  = 8,
  parameter int PERIOD = 256
) (
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [JIT_W-1:0] jit_i,
  output logic [T_W-1:0]          dly_o
);
  localparam int PW = T_W + CODE_W;
  localparam int SW = ((PW > JIT_W) ? PW : JIT_W) + 1;

  logic [PW-1:0]        prod;
  logic [PW-1:0]        nom;
  logic signed [SW-1:0] sum;

  assign prod = PW'(code_i) * PW'(PERIOD);
  assign nom  = prod >> CODE_W;
  assign sum  = $signed(SW'(nom)) + SW'(jit_i);

  always_comb begin
    if (sum < 0)                 dly_o = '0;
    else if (sum[SW-1:T_W] != 0) dly_o = '1;  // saturate
    else                         dly_o = sum[T_W-1:0];
  end
endmodule

// File: rtl/edt_slot.sv
module edt_slot #(
  parameter int T_W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [T_W-1:0] dly_i,
  input  logic           lvl_i,
  input  logic [T_W-1:0] step_i,
  output logic [T_W-1:0] rem_o,
  output logic           valid_o,
  output logic           lvl_o,
  output logic           hit_o
);
  logic [T_W-1:0] rem_q;
  logic           valid_q;
  logic           lvl_q;

  assign hit_o = valid_q && (rem_q == step_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      valid_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      rem_q   <= load_i ? dly_i : rem_q - step_i;
      valid_q <= (valid_q & ~hit_o) | load_i;
      if (load_i) lvl_q <= lvl_i;
    end
  end

  assign rem_o   = rem_q;
  assign valid_o = valid_q;
  assign lvl_o   = lvl_q;
endmodule

// File: rtl/edt_min_tree.sv
module edt_min_tree #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [N-1:0][W-1:0] in_i,
  input  logic [W-1:0]        pad_i,
  output logic [W-1:0]        min_o
);
  localparam int LG = (N <= 1) ? 0 : $clog2(N);
  localparam int NP = 1 << LG;

  // Heap layout: node 0 is the root, leaves start at NP-1.
  logic [W-1:0] node [2*NP-1];

  for (genvar k = 0; k < NP; k++) begin : g_leaf
    if (k < N) begin : g_in
      assign node[NP-1+k] = in_i[k];
    end else begin : g_pad
      assign node[NP-1+k] = pad_i;
    end
  end

  // Ties keep the lower-half value.
  for (genvar i = 0; i < NP-1; i++) begin : g_node
    assign node[i] = (node[2*i+2] < node[2*i+1]) ? node[2*i+2] : node[2*i+1];
  end

  assign min_o = node[0];
endmodule

// File: rtl/edge_delay_tracker.sv
module edge_delay_tracker #(
  parameter int DEPTH  = 4,
  parameter int CODE_W = 4,
  parameter int T_W    = 16,
  parameter int JIT_W  = 8,
  parameter int PERIOD = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    lvl_i,
  input  logic [CODE_W-1:0]       code_i,
  input  logic signed [JIT_W-1:0] jit_i,
  input  logic [T_W-1:0]          step_i,
  input  logic [T_W-1:0]          step_max_i,
  output logic [T_W-1:0]          req_o,
  output logic                    lvl_o
);
  localparam int PTR_W = edt_pkg::ptr_w(DEPTH);

  logic                      lvl_q;
  logic                      edge_w;
  logic [PTR_W-1:0]          ptr_q;
  logic [T_W-1:0]            dly;
  logic [DEPTH-1:0]          valid_q;
  logic [DEPTH-1:0]          hit;
  logic [DEPTH-1:0]          slv;
  logic [DEPTH-1:0][T_W-1:0] rem;
  logic [DEPTH-1:0][T_W-1:0] req_in;
  logic                      set_w;
  logic                      clr_w;
  logic                      out_q;

  assign edge_w = lvl_i ^ lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      ptr_q <= '0;
      out_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      out_q <= lvl_o;
      if (edge_w) ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  edt_delay_calc #(
    .CODE_W(CODE_W), .T_W(T_W), .JIT_W(JIT_W), .PERIOD(PERIOD)
  ) u_calc (
    .code_i(code_i),
    .jit_i (jit_i),
    .dly_o (dly)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic load;
    assign load = edge_w && (ptr_q == PTR_W'(k));

    edt_slot #(.T_W(T_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .dly_i  (dly),
      .lvl_i  (lvl_i),
      .step_i (step_i),
      .rem_o  (rem[k]),
      .valid_o(valid_q[k]),
      .lvl_o  (slv[k]),
      .hit_o  (hit[k])
    );

    assign req_in[k] = valid_q[k] ? rem[k] : step_max_i;
  end

  edt_min_tree #(.N(DEPTH), .W(T_W)) u_tree (
    .in_i (req_in),
    .pad_i(step_max_i),
    .min_o(req_o)
  );

  assign set_w = |(hit & slv);
  assign clr_w = |(hit & ~slv);
  assign lvl_o = (out_q & ~clr_w) | set_w;
endmodule

// File: rtl/edt_checker.sv
module edt_checker #(
  parameter int DEPTH = 4,
  parameter int T_W   = 16,
  parameter int PTR_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [T_W-1:0]   step_max_i,
  input logic [T_W-1:0]   req_o,
  input logic             lvl_o,
  input logic             edge_w,
  input logic [PTR_W-1:0] ptr_q,
  input logic [DEPTH-1:0] valid_q,
  input logic [DEPTH-1:0] hit
);
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_W'(DEPTH-1)); // R4

  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> ptr_q == (($past(ptr_q) == PTR_W'(DEPTH-1)) ? '0 : $past(ptr_q) + 1'b1)); // R4

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_w |=> $stable(ptr_q)); // R4

  AST_LOAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> valid_q[$past(ptr_q)]); // R5

  AST_FIRE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) && !edge_w |=> $countones(valid_q) < $past($countones(valid_q))); // R6

  AST_IDLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q == '0) |-> req_o == step_max_i); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |=> (hit != '0) || (lvl_o == $past(lvl_o))); // R8
endmodule

bind edge_delay_tracker edt_checker #(
  .DEPTH(DEPTH), .T_W(T_W), .PTR_W(PTR_W)
) u_edt_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .step_max_i(step_max_i),
  .req_o     (req_o),
  .lvl_o     (lvl_o),
  .edge_w    (edge_w),
  .ptr_q     (ptr_q),
  .valid_q   (valid_q),
  .hit       (hit)
);

// File: tb/test_edge_delay_tracker.sv
`timescale 1ns/1ps
module test_edge_delay_tracker;
  localparam int DEPTH = 4;
  localparam int CODE_W = 4;
  localparam int T_W = 16;
  localparam int JIT_W = 8;
  localparam int NV = 14;
  localparam logic [T_W-1:0] SMAX = 16'd100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lvl_i = 1'b0;
  logic [CODE_W-1:0] code_i = '0;
  logic signed [JIT_W-1:0] jit_i = '0;
  logic [T_W-1:0] step_i = '0;
  logic [T_W-1:0] step_max_i = SMAX;
  logic [T_W-1:0] req_o;
  logic lvl_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  edge_delay_tracker i_edge_delay_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_i), .code_i(code_i),
    .jit_i(jit_i), .step_i(step_i), .step_max_i(step_max_i),
    .req_o(req_o), .lvl_o(lvl_o)
  );

  // {tag, lvl, code, jit, step, exp_req, exp_lvl}
  localparam logic [49:0] VEC [NV] = '{
    {4'd1, 1'b0, 4'd0,  8'd0,   16'd100, 16'd100, 1'b0}, // R1 idle
    {4'd3, 1'b1, 4'd3,  8'd0,   16'd5,   16'd100, 1'b0}, // R3 rising edge, slot0 48
    {4'd2, 1'b1, 4'd3,  8'd0,   16'd8,   16'd48,  1'b0}, // R2 code*16
    {4'd5, 1'b0, 4'd1,  8'd2,   16'd10,  16'd40,  1'b0}, // R5 falling edge, slot1 18
    {4'd6, 1'b0, 4'd1,  8'd2,   16'd18,  16'd18,  1'b0}, // R6 slot1 fires, clears
    {4'd8, 1'b0, 4'd0,  8'd0,   16'd12,  16'd12,  1'b1}, // R8 slot0 fires, sets
    {4'd7, 1'b0, 4'd0,  8'd0,   16'd7,   16'd100, 1'b1}, // R7 all free
    {4'd2, 1'b1, 4'd2,  8'hD8,  16'd0,   16'd100, 1'b1}, // R2 negative -> 0
    {4'd2, 1'b0, 4'd5,  8'd0,   16'd0,   16'd0,   1'b1}, // R2 clamped slot2 fires
    {4'd5, 1'b0, 4'd0,  8'd0,   16'd30,  16'd80,  1'b1}, // R5 slot3 80
    {4'd8, 1'b1, 4'd15, 8'd5,   16'd50,  16'd50,  1'b0}, // R8 clear, slot0 reload 245
    {4'd7, 1'b1, 4'd0,  8'd0,   16'd1,   16'd100, 1'b0}, // R7 free slots cap at max
    {4'd4, 1'b1, 4'd0,  8'd0,   16'd244, 16'd100, 1'b1}, // R4 wrapped slot0 fires
    {4'd8, 1'b1, 4'd0,  8'd0,   16'd3,   16'd100, 1'b1}  // R8 hold
  };

  task automatic check(input int tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic [CODE_W-1:0] c,
                       input logic [JIT_W-1:0] j, input logic [T_W-1:0] s);
    @(negedge clk_i);
    lvl_i = l; code_i = c; jit_i = j; step_i = s;
    #1;
  endtask

  initial begin
    #1;
    check(1, "reset lvl_o", int'(lvl_o), 0);
    check(1, "reset req_o", int'(req_o), int'(SMAX));
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      drive(v[45], v[44:41], v[40:33], v[32:17]);
      check(int'(v[49:46]), $sformatf("row %0d req_o", i), int'(req_o), int'(v[16:1]));
      check(int'(v[49:46]), $sformatf("row %0d lvl_o", i), int'(lvl_o), int'(v[0]));
    end

    // R1: asynchronous reset clears a high output
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check(1, "async reset lvl_o", int'(lvl_o), 0);
    check(1, "async reset req_o", int'(req_o), int'(SMAX));
    @(negedge clk_i); rst_ni = 1'b1; lvl_i = 1'b0;

    // R9: opposite levels fire together
    drive(1'b1, 4'd1, 8'd0, 16'd0);
    drive(1'b0, 4'd1, 8'd0, 16'd0);
    check(7, "slot0 pending req_o", int'(req_o), 16);
    drive(1'b0, 4'd0, 8'd0, 16'd16);
    check(7, "tie req_o", int'(req_o), 16);
    check(9, "set wins lvl_o", int'(lvl_o), 1);
    drive(1'b0, 4'd0, 8'd0, 16'd3);
    check(6, "both freed req_o", int'(req_o), int'(SMAX));
    check(8, "hold after set lvl_o", int'(lvl_o), 1);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule